// File: doc/BRIEF.md
# Real-Time Clock Control and Status Register

This block is the 16-bit control and status word of a real-time clock. A CPU writes it through a simple register port: a write strobe with write data, and a read data bus that always shows the current contents. The word holds five kinds of state. There are the clock-source selects and an oscillator shut-off. There are the square-wave output controls. There are three sticky event flags (sub-second reload, time-of-day match, count ready), each with its own interrupt enable. There is a busy indicator. Last, there is the enable bit of the clock core, which has its own guard.

The clock core sends single-cycle event pulses into the block. The block drives the oscillator, clock-select and enable controls back to the core. It drives a square-wave pin as a data line plus an output enable, and it raises one registered interrupt request. The chip has two synchronous active-low resets. Power-on reset loads the whole word. System reset clears only the software-facing controls, so the clock setup and any pending alarms survive a warm restart.

Bit positions (software relies on them): 15 write guard, 14 oscillator off, 13 alternate clock, 12..10 reserved, 9 fast tap select, 8 square-wave enable, 7 sub-second flag, 6 time-of-day flag, 5 ready interrupt enable, 4 ready flag, 3 busy, 2 sub-second interrupt enable, 1 time-of-day interrupt enable, 0 clock enable.

Top module: `rtc_csr`

## Requirements
- R1: While `por_n` is low at a clock edge, the word becomes 0x4008 (bit 14 and bit 3 set, all else 0) and `irq` becomes 0. `por_n` takes priority over `rst_n`.
- R2: While `rst_n` is low and `por_n` is high at an edge, bits 15, 9, 8, 5 and 4 clear, bit 3 sets and `irq` clears. Bits 14, 13, 7, 6, 2, 1 and 0 keep their values, and event pulses are ignored.
- R3: A write changes bit 0 only if bit 15 was 1 before that write. Otherwise bit 0 keeps its value.
- R4: A write changes bit 13 only if bit 0 was 0 before that write. Otherwise bit 13 keeps its value.
- R5: Bits 15, 14, 9, 8, 5, 2 and 1 take the written value. Bits 12..10 always read 0. Writes do not affect bit 3.
- R6: `ev_subsec` sets bit 7 and `ev_tod` sets bit 6. Writing 0 to a flag clears it, and writing 1 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R7: `ev_upd_done` sets bit 4. `ev_upd_start` or a written 0 clears bit 4. If done arrives together with either clear, done wins.
- R8: Bit 3 sets on `ev_upd_start` and clears on `ev_upd_done`. If both arrive in the same cycle, done wins.
- R9: `irq` is 1 in the cycle after the word holds bit 7 with bit 2 set, bit 6 with bit 1 set, or bit 4 with bit 5 set. Otherwise `irq` is 0.
- R10: `sqw_oe` equals bit 8. When bit 8 is 1, `sqw_out` follows `tap_512hz` if bit 9 is 1 and `tap_1hz` if bit 9 is 0. When bit 8 is 0, `sqw_out` is 0.
- R11: `osc_dis`, `alt_clk_sel` and `rtc_en` show bits 14, 13 and 0 combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | System reset, synchronous, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| ev_subsec | input | 1 | Pulse: sub-second timer reloaded |
| ev_tod | input | 1 | Pulse: seconds count matched the alarm |
| ev_upd_start | input | 1 | Pulse: count update about to begin |
| ev_upd_done | input | 1 | Pulse: count update finished |
| tap_1hz | input | 1 | 1 Hz divider tap |
| tap_512hz | input | 1 | 512 Hz divider tap |
| rd_data | output | 16 | Current register contents |
| osc_dis | output | 1 | Crystal oscillator shut-off |
| alt_clk_sel | output | 1 | Run the core from the divided high-frequency clock |
| rtc_en | output | 1 | Clock core enable |
| sqw_out | output | 1 | Square-wave pin data |
| sqw_oe | output | 1 | Square-wave pin output enable |
| irq | output | 1 | Registered interrupt request |

## Verification
Directed sequences come first. They try the two guards with the guard open and closed, which shows whether the gating looks at the stored value or the incoming one. They also try a flag set arriving in the same cycle as a software clear, and an update start arriving together with an update done, so that set-over-clear priority is visible at the read port. A warm reset taken with every field loaded separates the bits that survive from the bits that clear. After that, several thousand cycles of random writes, events, taps and sparse resets are compared each cycle against a bench model of the word. These mix guard states and flag races in orders the directed part does not reach.

// File: rtl/rtc_csr_pkg.sv
// Package: bit positions, reset values and the control-field type of the
// real-time clock control/status word. Positions are fixed because
// software decodes them.
package rtc_csr_pkg;
    localparam int unsigned DW       = 16;
    localparam int unsigned NFLAG    = 3;   // 0: sub-second, 1: time-of-day, 2: ready
    localparam int unsigned B_WE     = 15;
    localparam int unsigned B_OSCOFF = 14;
    localparam int unsigned B_ALT    = 13;
    localparam int unsigned B_FAST   = 9;
    localparam int unsigned B_SQE    = 8;
    localparam int unsigned B_SSF    = 7;
    localparam int unsigned B_TODF   = 6;
    localparam int unsigned B_RDYIE  = 5;
    localparam int unsigned B_RDY    = 4;
    localparam int unsigned B_BUSY   = 3;
    localparam int unsigned B_SSIE   = 2;
    localparam int unsigned B_TODIE  = 1;
    localparam int unsigned B_EN     = 0;

    // Flags that a system reset clears (ready only)
    localparam logic [NFLAG-1:0] FLAG_WARM_CLR = 3'b100;

    typedef struct packed {
        logic we;
        logic osc_off;
        logic alt;
        logic fast;
        logic sqe;
        logic rdy_ie;
        logic ss_ie;
        logic tod_ie;
        logic en;
    } ctrl_t;

    localparam ctrl_t CTRL_COLD = '{we: 1'b0, osc_off: 1'b1, alt: 1'b0, fast: 1'b0,
                                    sqe: 1'b0, rdy_ie: 1'b0, ss_ie: 1'b0,
                                    tod_ie: 1'b0, en: 1'b0};
endpackage

// File: rtl/rtc_csr_ctrl.sv
// Control fields of the word. Holds the software-written controls and
// applies the two guards: the enable bit needs the stored write guard,
// and the clock select needs the stored enable to be 0.
// Assumes: por_n takes priority over rst_n, and both resets are synchronous.
module rtc_csr_ctrl
    import rtc_csr_pkg::*;
(
    input  logic  clk,
    input  logic  por_n,
    input  logic  rst_n,
    input  logic  wr_en,
    input  ctrl_t wr_ctrl,
    output ctrl_t ctrl_q
);
    // Purpose: reset loading and guarded software update of the controls
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ctrl_q <= CTRL_COLD;
        end else if (!rst_n) begin
            ctrl_q.we     <= 1'b0;
            ctrl_q.fast   <= 1'b0;
            ctrl_q.sqe    <= 1'b0;
            ctrl_q.rdy_ie <= 1'b0;
        end else if (wr_en) begin
            ctrl_q.we      <= wr_ctrl.we;
            ctrl_q.osc_off <= wr_ctrl.osc_off;
            ctrl_q.fast    <= wr_ctrl.fast;
            ctrl_q.sqe     <= wr_ctrl.sqe;
            ctrl_q.rdy_ie  <= wr_ctrl.rdy_ie;
            ctrl_q.ss_ie   <= wr_ctrl.ss_ie;
            ctrl_q.tod_ie  <= wr_ctrl.tod_ie;
            if (ctrl_q.we)
                ctrl_q.en  <= wr_ctrl.en;
            if (!ctrl_q.en)
                ctrl_q.alt <= wr_ctrl.alt;
        end
    end
endmodule

// File: rtl/rtc_csr_flag.sv
// One sticky event flag. A hardware set beats every clear. The clear
// comes from a hardware pulse or from software writing 0.
// WARM_CLR picks whether a system reset clears the flag or keeps it.
// Assumes: event pulses last one cycle.
module rtc_csr_flag #(
    parameter bit WARM_CLR = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic sw_wr_i,
    input  logic sw_val_i,
    output logic q_o
);
    // Purpose: hold the flag with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!por_n)
            q_o <= 1'b0;
        else if (!rst_n) begin
            if (WARM_CLR)
                q_o <= 1'b0;
        end else if (set_i)
            q_o <= 1'b1;
        else if (hw_clr_i || (sw_wr_i && !sw_val_i))
            q_o <= 1'b0;
    end
endmodule

// File: rtl/rtc_csr_irq.sv
// Interrupt combiner: the OR of N enabled sources, registered once.
// Assumes: either reset clears the request.
module rtc_csr_irq #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] ena_i,
    output logic         irq_o
);
    // Purpose: register the enabled-source OR
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |(src_i & ena_i);
    end
endmodule

// File: rtl/rtc_csr.sv
// Top: the real-time clock control/status word. It joins the control
// fields, three sticky flags, the busy bit and the interrupt combiner,
// and muxes the square-wave pin. Assumes single-cycle event pulses
// from the core and a read port that shows the register with no delay.
module rtc_csr
    import rtc_csr_pkg::*;
(
    input  logic          clk,
    input  logic          por_n,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ev_subsec,
    input  logic          ev_tod,
    input  logic          ev_upd_start,
    input  logic          ev_upd_done,
    input  logic          tap_1hz,
    input  logic          tap_512hz,
    output logic [DW-1:0] rd_data,
    output logic          osc_dis,
    output logic          alt_clk_sel,
    output logic          rtc_en,
    output logic          sqw_out,
    output logic          sqw_oe,
    output logic          irq
);
    ctrl_t            wr_ctrl, ctrl_q;
    logic [NFLAG-1:0] fl_set, fl_hwclr, fl_swval, fl_q, fl_ena;
    logic             busy_q;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[12:10], wr_data[B_BUSY]};

    // Purpose: pick the control fields out of the write data
    always_comb begin
        wr_ctrl.we      = wr_data[B_WE];
        wr_ctrl.osc_off = wr_data[B_OSCOFF];
        wr_ctrl.alt     = wr_data[B_ALT];
        wr_ctrl.fast    = wr_data[B_FAST];
        wr_ctrl.sqe     = wr_data[B_SQE];
        wr_ctrl.rdy_ie  = wr_data[B_RDYIE];
        wr_ctrl.ss_ie   = wr_data[B_SSIE];
        wr_ctrl.tod_ie  = wr_data[B_TODIE];
        wr_ctrl.en      = wr_data[B_EN];
    end

    rtc_csr_ctrl u_ctrl (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ctrl (wr_ctrl),
        .ctrl_q  (ctrl_q)
    );

    // Flag sources in a fixed order: 0 sub-second, 1 time-of-day, 2 ready
    assign fl_set   = {ev_upd_done, ev_tod, ev_subsec};
    assign fl_hwclr = {ev_upd_start, 1'b0, 1'b0};
    assign fl_swval = {wr_data[B_RDY], wr_data[B_TODF], wr_data[B_SSF]};
    assign fl_ena   = {ctrl_q.rdy_ie, ctrl_q.tod_ie, ctrl_q.ss_ie};

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        rtc_csr_flag #(.WARM_CLR(FLAG_WARM_CLR[i])) u_flag (
            .clk      (clk),
            .por_n    (por_n),
            .rst_n    (rst_n),
            .set_i    (fl_set[i]),
            .hw_clr_i (fl_hwclr[i]),
            .sw_wr_i  (wr_en),
            .sw_val_i (fl_swval[i]),
            .q_o      (fl_q[i])
        );
    end

    // Purpose: busy bit, high from update start until update done
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            busy_q <= 1'b1;
        else if (ev_upd_done)
            busy_q <= 1'b0;
        else if (ev_upd_start)
            busy_q <= 1'b1;
    end

    rtc_csr_irq #(.N(NFLAG)) u_irq (
        .clk   (clk),
        .por_n (por_n),
        .rst_n (rst_n),
        .src_i (fl_q),
        .ena_i (fl_ena),
        .irq_o (irq)
    );

    // Purpose: put the read word together; reserved bits read 0
    always_comb begin
        rd_data           = '0;
        rd_data[B_WE]     = ctrl_q.we;
        rd_data[B_OSCOFF] = ctrl_q.osc_off;
        rd_data[B_ALT]    = ctrl_q.alt;
        rd_data[B_FAST]   = ctrl_q.fast;
        rd_data[B_SQE]    = ctrl_q.sqe;
        rd_data[B_SSF]    = fl_q[0];
        rd_data[B_TODF]   = fl_q[1];
        rd_data[B_RDYIE]  = ctrl_q.rdy_ie;
        rd_data[B_RDY]    = fl_q[2];
        rd_data[B_BUSY]   = busy_q;
        rd_data[B_SSIE]   = ctrl_q.ss_ie;
        rd_data[B_TODIE]  = ctrl_q.tod_ie;
        rd_data[B_EN]     = ctrl_q.en;
    end

    // Purpose: core controls and square-wave pin mux
    always_comb begin
        osc_dis     = ctrl_q.osc_off;
        alt_clk_sel = ctrl_q.alt;
        rtc_en      = ctrl_q.en;
        sqw_oe      = ctrl_q.sqe;
        sqw_out     = ctrl_q.sqe & (ctrl_q.fast ? tap_512hz : tap_1hz);
    end
endmodule

// File: rtl/rtc_csr_chk.sv
// Checker for rtc_csr. It watches only the ports and is bound to every
// instance of the top.
module rtc_csr_chk (
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        wr_en,
    input logic        ev_upd_done,
    input logic [15:0] rd_data,
    input logic        alt_clk_sel,
    input logic        rtc_en,
    input logic        sqw_out,
    input logic        sqw_oe,
    input logic        irq
);
    // R1
    cold_load_chk: assert property (@(posedge clk)
        !por_n |=> (rd_data == 16'h4008 && !irq));

    // R2
    warm_clear_chk: assert property (@(posedge clk)
        (por_n && !rst_n) |=> (rd_data[3] && !rd_data[15] && !rd_data[4] && !irq));

    // R3
    en_guard_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && !rd_data[15]) |=> $stable(rtc_en));

    // R4
    alt_guard_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_en && rtc_en) |=> $stable(alt_clk_sel));

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[12:10] == 3'b000);

    // R7
    ready_set_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ev_upd_done |=> rd_data[4]);

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ev_upd_done |=> !rd_data[3]);

    // R9
    irq_ss_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (rd_data[7] && rd_data[2]) |=> irq);

    // R10
    sqw_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sqw_oe |-> !sqw_out);
endmodule

bind rtc_csr rtc_csr_chk u_rtc_csr_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .ev_upd_done (ev_upd_done),
    .rd_data     (rd_data),
    .alt_clk_sel (alt_clk_sel),
    .rtc_en      (rtc_en),
    .sqw_out     (sqw_out),
    .sqw_oe      (sqw_oe),
    .irq         (irq)
);

// File: tb/tb_rtc_csr.sv
`timescale 1ns/1ps
module tb_rtc_csr;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ev_subsec = 0, ev_tod = 0, ev_upd_start = 0, ev_upd_done = 0;
    logic        tap_1hz = 0, tap_512hz = 0;
    logic [15:0] rd_data;
    logic        osc_dis, alt_clk_sel, rtc_en, sqw_out, sqw_oe, irq;

    int unsigned total = 0, bad = 0;
    bit          finished = 0;
    logic [15:0] m_reg = 16'h4008;
    logic        m_irq = 1'b0;
    int unsigned seed_dummy;

    always #2.5 clk = ~clk;

    rtc_csr dut (.*);

    // Next word, written from the requirements
    function automatic logic [15:0] next_word(logic [15:0] c, logic por, logic sys,
            logic we, logic [15:0] d, logic es, logic et, logic us, logic ud);
        logic [15:0] r;
        r = c;
        if (!por) return 16'h4008;
        if (!sys) begin
            r[15] = 0; r[9] = 0; r[8] = 0; r[5] = 0; r[4] = 0; r[3] = 1;
            return r;
        end
        if (we) begin
            r[15] = d[15]; r[14] = d[14]; r[9] = d[9]; r[8] = d[8];
            r[5] = d[5]; r[2] = d[2]; r[1] = d[1];
            if (c[15]) r[0] = d[0];
            if (!c[0]) r[13] = d[13];
            if (!d[7]) r[7] = 0;
            if (!d[6]) r[6] = 0;
            if (!d[4]) r[4] = 0;
        end
        if (us) begin r[4] = 0; r[3] = 1; end
        if (ud) begin r[4] = 1; r[3] = 0; end
        if (es) r[7] = 1;
        if (et) r[6] = 1;
        return r;
    endfunction

    function automatic logic next_irq(logic [15:0] c, logic por, logic sys);
        if (!por || !sys) return 1'b0;
        return (c[7] & c[2]) | (c[6] & c[1]) | (c[4] & c[5]);
    endfunction

    task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge
    task automatic step(string req, logic por, logic sys, logic we, logic [15:0] d,
                        logic es, logic et, logic us, logic ud, logic t1, logic t512);
        logic exp_sqw;
        por_n = por; rst_n = sys; wr_en = we; wr_data = d;
        ev_subsec = es; ev_tod = et; ev_upd_start = us; ev_upd_done = ud;
        tap_1hz = t1; tap_512hz = t512;
        @(posedge clk);
        m_irq = next_irq(m_reg, por, sys);
        m_reg = next_word(m_reg, por, sys, we, d, es, et, us, ud);
        @(negedge clk);
        exp_sqw = m_reg[8] & (m_reg[9] ? tap_512hz : tap_1hz);
        check(req, "rd_data", rd_data, m_reg);
        check(req, "irq", {15'b0, irq}, {15'b0, m_irq});
        check(req, "ctl pins", {13'b0, osc_dis, alt_clk_sel, rtc_en},
              {13'b0, m_reg[14], m_reg[13], m_reg[0]});
        check(req, "sqw", {14'b0, sqw_oe, sqw_out}, {14'b0, m_reg[8], exp_sqw});
    endtask

    task automatic wr(string req, logic [15:0] d);
        step(req, 1, 1, 1, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(string req);
        step(req, 1, 1, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        seed_dummy = $urandom(32'd1357);
        @(negedge clk);
        // R1: cold load, with the warm reset also low
        step("R1", 0, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
        step("R1", 0, 1, 1, 16'hFFFF, 1, 1, 1, 1, 1, 1);
        idle("R1");
        // R3: the enable write is blocked while the guard is 0
        wr("R3", 16'h0001);
        wr("R3", 16'h8000);
        wr("R3", 16'h8001);          // guard was 1, so the enable sets
        idle("R11");
        // R4: the clock select stays frozen while enabled
        wr("R4", 16'h8001 | 16'h2000);
        wr("R4", 16'h8000);          // enable clears; guard still 1
        wr("R4", 16'h2000);          // enable was 0, so select sets
        // R3: guard now 0, a write of 1 to the enable is ignored
        wr("R3", 16'h2001);
        // R5: plain bits, reserved and busy
        wr("R5", 16'hFFFF);
        wr("R5", 16'h1C08);
        // R8: update pulses
        step("R8", 1, 1, 0, 0, 0, 0, 1, 0, 0, 0);
        step("R8", 1, 1, 0, 0, 0, 0, 0, 1, 0, 0);
        step("R8", 1, 1, 0, 0, 0, 0, 1, 1, 0, 0);
        // R7: a start together with a done leaves ready set; a written 0 clears it
        step("R7", 1, 1, 0, 0, 0, 0, 1, 1, 0, 0);
        wr("R7", 16'h0000);
        step("R7", 1, 1, 1, 16'h0000, 0, 0, 0, 1, 0, 0);
        step("R7", 1, 1, 0, 0, 0, 0, 1, 0, 0, 0);
        // R6: the flags set, a race with a clear, write 1 keeps, write 0 clears
        step("R6", 1, 1, 0, 0, 1, 1, 0, 0, 0, 0);
        step("R6", 1, 1, 1, 16'h00C0, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 1, 1, 16'h0000, 1, 0, 0, 0, 0, 0);
        step("R6", 1, 1, 1, 16'h0000, 0, 0, 0, 0, 0, 0);
        // R9: each source with its enable
        wr("R9", 16'h0004);
        step("R9", 1, 1, 0, 0, 1, 0, 0, 0, 0, 0);
        idle("R9");
        wr("R9", 16'h0002 | 16'h0080);
        step("R9", 1, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        idle("R9");
        wr("R9", 16'h0020 | 16'h0040);
        step("R9", 1, 1, 0, 0, 0, 0, 0, 1, 0, 0);
        idle("R9");
        // R10: tap selection and the disabled pin
        wr("R10", 16'h0100);
        step("R10", 1, 1, 0, 0, 0, 0, 0, 0, 1, 0);
        wr("R10", 16'h0300);
        step("R10", 1, 1, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R10", 1, 1, 0, 0, 0, 0, 0, 0, 1, 0);
        wr("R10", 16'h0200);
        step("R10", 1, 1, 0, 0, 0, 0, 0, 0, 1, 1);
        // R2: load every field, then a warm reset with events present
        wr("R2", 16'h8000);
        wr("R2", 16'hE3E7);
        step("R2", 1, 1, 0, 0, 1, 1, 0, 1, 0, 0);
        step("R2", 1, 0, 1, 16'h0000, 1, 1, 1, 0, 1, 1);
        idle("R2");
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic rp, rs;
            rp = ($urandom % 400) != 0;
            rs = ($urandom % 150) != 0;
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11", rp, rs, ($urandom % 3) == 0,
                 16'($urandom), ($urandom % 7) == 0, ($urandom % 9) == 0,
                 ($urandom % 6) == 0, ($urandom % 6) == 0,
                 1'($urandom), 1'($urandom));
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule